// File: doc/BRIEF.md
# USB Host IN Pipe Controller

This block runs a single IN pipe on the host side of a USB link. While the pipe is open it asks a separate transaction engine to send IN tokens. It either asks a set number of times and then closes the pipe by itself, or it keeps asking until software closes it. Each data packet that comes back is written into one of one or two local data banks. Software then drains the current bank byte by byte through a pop strobe.

Four status bits are kept:

- a frozen bit that gates token generation;
- a received-data flag that drives the interrupt together with an enable;
- an ownership flag that shows software holds a filled bank;
- a read-allowed bit that stays high while the current bank still has unread bytes.

When software releases a bank, the ownership flag clears. With two banks, the read side also moves to the other bank, and both flags are rebuilt at once from that bank's fill state.

The transaction engine sees a simple handshake. `tok_req` asks for a token and `tok_ack` accepts it. After an accepted request the block waits for exactly one packet on the receive strobes before it asks again.

Top module: `usb_in_pipe`

## Requirements
- R1: With `cfg_endless` low (value 0 = counted), once the pipe is opened the block accepts exactly `cfg_req_count`+1 token requests, then sets `frozen` by itself in the cycle after the last accepted request.
- R2: With `cfg_endless` high (value 1 = endless), `frozen` never sets by itself; requests continue until `sw_freeze_set` is pulsed.
- R3: `frozen` is high after reset. `tok_req` is never high while `frozen` is high. A `sw_freeze_clr` pulse opens the pipe, and `tok_req` rises in the next cycle if a bank is free.
- R4: The cycle a bank being read becomes full, `rx_flag` and `own_flag` both go high together. `irq` is high exactly when `rx_flag` and `irq_en` are both high.
- R5: A `sw_rx_ack` pulse clears `rx_flag`. It leaves `own_flag`, `rd_allowed` and the bank contents unchanged.
- R6: A `sw_release` pulse while `own_flag` is high empties the current bank. With `cfg_dual_bank` high, the read side moves to the other bank, and the bytes popped next come from that bank.
- R7: After a release, `rx_flag` and `own_flag` take the full state of the new current bank. They are high in the very next cycle if that bank is already full, and low otherwise. In single-bank mode they are always low after a release.
- R8: `rd_allowed` is high while the current bank is full and still holds unpopped bytes. It falls after the last byte of the packet is popped.
- R9: A packet ends on `rx_last`, or on its 64th byte (`BANK_BYTES`) when `rx_last` never arrives. Either way the bank is marked full, and only the bytes received are readable.
- R10: `tok_req` stays low while a request is awaiting its packet, and while the bank next in fill order is full (all banks full). No request is counted while stalled.
- R11: A `sw_pop` while `rd_allowed` is low returns `rd_data` = 0 and changes no flag.
- R12: Every `sw_freeze_clr` on a frozen pipe reloads the request budget from `cfg_req_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_endless | input | 1 | 0 = counted requests, 1 = endless requests |
| cfg_req_count | input | REQ_W | Request budget minus one for counted mode |
| cfg_dual_bank | input | 1 | 1 = two banks in ping-pong, 0 = one bank; changed only during reset |
| irq_en | input | 1 | Interrupt enable for the received-data flag |
| sw_freeze_set | input | 1 | Software strobe to close the pipe |
| sw_freeze_clr | input | 1 | Software strobe to open the pipe |
| sw_rx_ack | input | 1 | Software strobe clearing the received-data flag |
| sw_release | input | 1 | Software strobe releasing the current bank |
| sw_pop | input | 1 | Software strobe popping one byte from the current bank |
| tok_req | output | 1 | Request for one IN token |
| tok_ack | input | 1 | Engine accepts the pending token request |
| rx_valid | input | 1 | Received packet byte valid |
| rx_data | input | DATA_W | Received packet byte |
| rx_last | input | 1 | Marks the final byte of a packet |
| frozen | output | 1 | Pipe closed; no requests |
| rx_flag | output | 1 | Received-data flag |
| own_flag | output | 1 | Software holds a filled bank |
| rd_allowed | output | 1 | Current bank has unread bytes |
| rd_data | output | DATA_W | Byte at the read pointer of the current bank; 0 when none |
| irq | output | 1 | Interrupt output |

## Verification
The bench builds the block with its default parameters: 64-byte banks, an 8-bit request budget and 8-bit data. It runs both bank configurations through the runtime bank-count input, with a reset between them. The bank size is 64, so one packet with no end marker reaches the automatic full point, and filling both banks reaches the stall. The single-bank counted run opens the pipe twice with different budgets, which exercises self-freezing and the reload. The two-bank endless run covers release onto an already full bank.

// File: rtl/inpipe_pkg.sv
package inpipe_pkg;

    localparam int DEF_DATA_W     = 8;
    localparam int DEF_BANK_BYTES = 64;
    localparam int DEF_REQ_W      = 8;
    localparam int NUM_BANKS      = 2;

    typedef enum logic {
        REQ_COUNTED = 1'b0,
        REQ_ENDLESS = 1'b1
    } req_mode_e;

    typedef struct packed {
        logic rx;
        logic own;
    } pipe_flags_t;

    // Index of the bank that follows idx in ping-pong order.
    function automatic logic next_bank(input logic idx, input logic dual);
        return dual ? ~idx : idx;
    endfunction

endpackage

// File: rtl/inpipe_bank.sv
module inpipe_bank #(
    parameter int DEPTH = 64,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_last,
    input  logic          clr,
    input  logic          pop,
    output logic          full,
    output logic          closing,
    output logic          has_data,
    output logic [DW-1:0] rd_data
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int PW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [CW-1:0] cnt;
    logic [CW-1:0] rptr;
    logic          accept;

    assign accept   = wr_en && !full;
    assign closing  = accept && (wr_last || cnt == CW'(DEPTH - 1));
    assign has_data = full && (rptr != cnt);
    assign rd_data  = has_data ? mem[rptr[PW-1:0]] : '0;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt  <= '0;
            rptr <= '0;
            full <= 1'b0;
        end else begin
            if (accept) begin
                cnt <= cnt + 1'b1;
                if (closing) full <= 1'b1;
            end
            if (pop && has_data) rptr <= rptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) mem[cnt[PW-1:0]] <= wr_data;
    end

endmodule

// File: rtl/inpipe_req_gen.sv
module inpipe_req_gen
    import inpipe_pkg::*;
#(
    parameter int REQ_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  req_mode_e        mode,
    input  logic [REQ_W-1:0] budget,
    input  logic             freeze_set,
    input  logic             freeze_clr,
    input  logic             can_issue,
    input  logic             tok_ack,
    output logic             tok_req,
    output logic             frozen
);
    logic [REQ_W-1:0] left;
    logic             fire;

    assign tok_req = !frozen && can_issue;
    assign fire    = tok_req && tok_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            frozen <= 1'b1;
            left   <= '0;
        end else if (freeze_set) begin
            frozen <= 1'b1;
        end else if (freeze_clr && frozen) begin
            frozen <= 1'b0;
            left   <= budget;
        end else if (fire && mode == REQ_COUNTED) begin
            if (left == '0) frozen <= 1'b1;
            else            left   <= left - 1'b1;
        end
    end

endmodule

// File: rtl/usb_in_pipe.sv
module usb_in_pipe
    import inpipe_pkg::*;
#(
    parameter int BANK_BYTES = DEF_BANK_BYTES,
    parameter int REQ_W      = DEF_REQ_W,
    parameter int DATA_W     = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_endless,
    input  logic [REQ_W-1:0]  cfg_req_count,
    input  logic              cfg_dual_bank,
    input  logic              irq_en,
    input  logic              sw_freeze_set,
    input  logic              sw_freeze_clr,
    input  logic              sw_rx_ack,
    input  logic              sw_release,
    input  logic              sw_pop,
    output logic              tok_req,
    input  logic              tok_ack,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_last,
    output logic              frozen,
    output logic              rx_flag,
    output logic              own_flag,
    output logic              rd_allowed,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic [NUM_BANKS-1:0] bank_full, bank_close, bank_has;
    logic [NUM_BANKS-1:0] bank_wr, bank_clr, bank_pop;
    logic [DATA_W-1:0]    bank_rd [NUM_BANKS];

    logic        cur_idx, fill_idx, pending;
    logic        release_ok, can_issue, fire, nxt_idx, nxt_full;
    pipe_flags_t flags;

    assign release_ok = sw_release && flags.own;
    assign can_issue  = !pending && !bank_full[fill_idx];
    assign fire       = tok_req && tok_ack;

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            assign bank_wr[b]  = rx_valid && pending && (fill_idx == 1'(b));
            assign bank_clr[b] = release_ok && (cur_idx == 1'(b));
            assign bank_pop[b] = sw_pop && (cur_idx == 1'(b));

            inpipe_bank #(.DEPTH(BANK_BYTES), .DW(DATA_W)) u_bank (
                .clk      (clk),
                .rst      (rst),
                .wr_en    (bank_wr[b]),
                .wr_data  (rx_data),
                .wr_last  (rx_last),
                .clr      (bank_clr[b]),
                .pop      (bank_pop[b]),
                .full     (bank_full[b]),
                .closing  (bank_close[b]),
                .has_data (bank_has[b]),
                .rd_data  (bank_rd[b])
            );
        end
    endgenerate

    inpipe_req_gen #(.REQ_W(REQ_W)) u_req (
        .clk        (clk),
        .rst        (rst),
        .mode       (req_mode_e'(cfg_endless)),
        .budget     (cfg_req_count),
        .freeze_set (sw_freeze_set),
        .freeze_clr (sw_freeze_clr),
        .can_issue  (can_issue),
        .tok_ack    (tok_ack),
        .tok_req    (tok_req),
        .frozen     (frozen)
    );

    // One packet in flight at a time; it closes on the filling bank.
    always_ff @(posedge clk) begin
        if (rst) begin
            pending  <= 1'b0;
            fill_idx <= 1'b0;
        end else begin
            if (fire)             pending <= 1'b1;
            else if (|bank_close) pending <= 1'b0;
            if (|bank_close) fill_idx <= next_bank(fill_idx, cfg_dual_bank);
        end
    end

    // Flag state follows the bank under the read pointer.
    assign nxt_idx  = next_bank(cur_idx, cfg_dual_bank);
    assign nxt_full = cfg_dual_bank && (bank_full[nxt_idx] || bank_close[nxt_idx]);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_idx <= 1'b0;
            flags   <= '0;
        end else if (release_ok) begin
            cur_idx   <= nxt_idx;
            flags.rx  <= nxt_full;
            flags.own <= nxt_full;
        end else if (bank_close[cur_idx]) begin
            flags.rx  <= 1'b1;
            flags.own <= 1'b1;
        end else if (sw_rx_ack) begin
            flags.rx <= 1'b0;
        end
    end

    assign rx_flag    = flags.rx;
    assign own_flag   = flags.own;
    assign rd_allowed = bank_has[cur_idx];
    assign rd_data    = bank_rd[cur_idx];
    assign irq        = flags.rx && irq_en;

endmodule

// File: rtl/usb_in_pipe_chk.sv
module usb_in_pipe_chk (
    input logic clk,
    input logic rst,
    input logic cfg_endless,
    input logic sw_freeze_set,
    input logic sw_rx_ack,
    input logic sw_release,
    input logic tok_req,
    input logic frozen,
    input logic rx_flag,
    input logic own_flag,
    input logic rd_allowed
);
    p_no_req_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        frozen |-> !tok_req);

    p_flags_pair_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(own_flag) |-> rx_flag);

    p_ack_keeps_own_r5: assert property (@(posedge clk) disable iff (rst)
        (sw_rx_ack && !sw_release && own_flag) |=> own_flag);

    p_rx_needs_own_r7: assert property (@(posedge clk) disable iff (rst)
        rx_flag |-> own_flag);

    p_endless_open_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_endless && !frozen && !sw_freeze_set) |=> !frozen);

    p_read_needs_own_r8: assert property (@(posedge clk) disable iff (rst)
        rd_allowed |-> own_flag);
endmodule

bind usb_in_pipe usb_in_pipe_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_endless   (cfg_endless),
    .sw_freeze_set (sw_freeze_set),
    .sw_rx_ack     (sw_rx_ack),
    .sw_release    (sw_release),
    .tok_req       (tok_req),
    .frozen        (frozen),
    .rx_flag       (rx_flag),
    .own_flag      (own_flag),
    .rd_allowed    (rd_allowed)
);

// File: tb/usb_in_pipe_tb.sv
module usb_in_pipe_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_endless = 1'b0;
    logic [7:0] cfg_req_count = 8'd0;
    logic       cfg_dual_bank = 1'b0;
    logic       irq_en = 1'b1;
    logic       sw_freeze_set = 1'b0, sw_freeze_clr = 1'b0;
    logic       sw_rx_ack = 1'b0, sw_release = 1'b0, sw_pop = 1'b0;
    logic       tok_ack = 1'b0, rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0] rx_data = 8'd0;
    logic       tok_req, frozen, rx_flag, own_flag, rd_allowed, irq;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    int n_req  = 0;
    bit done   = 0;
    logic [7:0] seed = 8'h11;
    logic [7:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_in_pipe u_dut (
        .clk(clk), .rst(rst), .cfg_endless(cfg_endless), .cfg_req_count(cfg_req_count),
        .cfg_dual_bank(cfg_dual_bank), .irq_en(irq_en), .sw_freeze_set(sw_freeze_set),
        .sw_freeze_clr(sw_freeze_clr), .sw_rx_ack(sw_rx_ack), .sw_release(sw_release),
        .sw_pop(sw_pop), .tok_req(tok_req), .tok_ack(tok_ack), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_last(rx_last), .frozen(frozen), .rx_flag(rx_flag),
        .own_flag(own_flag), .rd_allowed(rd_allowed), .rd_data(rd_data), .irq(irq)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic dual, input logic endless);
        rst = 1'b1;
        cfg_dual_bank = dual;
        cfg_endless = endless;
        repeat (3) tick();
        rst = 1'b0;
        tick();
    endtask

    task automatic pulse_clr();  sw_freeze_clr = 1'b1; tick(); sw_freeze_clr = 1'b0; endtask
    task automatic pulse_set();  sw_freeze_set = 1'b1; tick(); sw_freeze_set = 1'b0; endtask
    task automatic pulse_ack();  sw_rx_ack = 1'b1; tick(); sw_rx_ack = 1'b0; endtask
    task automatic pulse_rel();  sw_release = 1'b1; tick(); sw_release = 1'b0; endtask

    // Driver: answers one token request with n bytes, pushing them to the scoreboard.
    task automatic serve(input int n, input bit use_last);
        int waited = 0;
        while (!tok_req && waited < 200) begin
            tick();
            waited++;
        end
        chk("R3 tok_req seen", 32'(tok_req), 32'd1);
        tok_ack = 1'b1;
        tick();
        tok_ack = 1'b0;
        n_req++;
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1;
            rx_data  = seed;
            rx_last  = use_last && (i == n - 1);
            exp_q.push_back(seed);
            seed = seed + 8'd7;
            tick();
        end
        rx_valid = 1'b0;
        rx_last  = 1'b0;
    endtask

    // Monitor: pops n bytes and compares with the scoreboard.
    task automatic drain(input int n, input string req);
        logic [7:0] e;
        for (int i = 0; i < n; i++) begin
            e = exp_q.pop_front();
            chk({req, " rd_allowed"}, 32'(rd_allowed), 32'd1);
            chk({req, " data"}, 32'(rd_data), 32'(e));
            sw_pop = 1'b1;
            tick();
            sw_pop = 1'b0;
        end
        chk("R8 rd_allowed low after drain", 32'(rd_allowed), 32'd0);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R3 actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick();
        // ---- single bank, counted ----
        cfg_req_count = 8'd2;
        do_reset(1'b0, 1'b0);
        chk("R3 frozen at reset", 32'(frozen), 32'd1);
        chk("R3 no req at reset", 32'(tok_req), 32'd0);
        chk("R8 rd_allowed at reset", 32'(rd_allowed), 32'd0);
        chk("R4 own at reset", 32'(own_flag), 32'd0);
        pulse_clr();
        chk("R3 req after open", 32'(tok_req), 32'd1);
        for (int k = 0; k < 3; k++) begin
            serve(4 + k, 1'b1);
            chk("R4 rx_flag on full", 32'(rx_flag), 32'd1);
            chk("R4 own_flag on full", 32'(own_flag), 32'd1);
            chk("R4 irq", 32'(irq), 32'd1);
            chk("R10 stall bank full", 32'(tok_req), 32'd0);
            chk("R1 frozen after budget", 32'(frozen), (k == 2) ? 32'd1 : 32'd0);
            pulse_ack();
            chk("R5 rx cleared", 32'(rx_flag), 32'd0);
            chk("R5 own kept", 32'(own_flag), 32'd1);
            chk("R5 rd kept", 32'(rd_allowed), 32'd1);
            chk("R4 irq off", 32'(irq), 32'd0);
            drain(4 + k, "R9");
            pulse_rel();
            chk("R6 own cleared", 32'(own_flag), 32'd0);
            chk("R7 single rx low", 32'(rx_flag), 32'd0);
            chk("R10 req after free", 32'(tok_req), (k == 2) ? 32'd0 : 32'd1);
        end
        repeat (10) tick();
        chk("R1 request total", 32'(n_req), 32'd3);
        chk("R1 stays frozen", 32'(tok_req), 32'd0);
        // reload with a new budget
        cfg_req_count = 8'd0;
        pulse_clr();
        chk("R12 reopened", 32'(frozen), 32'd0);
        serve(2, 1'b1);
        chk("R12 budget of one", 32'(frozen), 32'd1);
        irq_en = 1'b0;
        tick();
        chk("R4 irq masked", 32'(irq), 32'd0);
        chk("R4 flag kept masked", 32'(rx_flag), 32'd1);
        irq_en = 1'b1;
        drain(2, "R12");
        pulse_ack();
        pulse_rel();

        // ---- two banks, endless ----
        exp_q.delete();
        n_req = 0;
        do_reset(1'b1, 1'b0 | 1'b1);
        pulse_clr();
        serve(3, 1'b1);
        chk("R4 bank0 flags", 32'({rx_flag, own_flag}), 32'd3);
        chk("R10 second bank free", 32'(tok_req), 32'd1);
        serve(64, 1'b0);
        chk("R10 stall all full", 32'(tok_req), 32'd0);
        chk("R2 not frozen", 32'(frozen), 32'd0);
        drain(3, "R8");
        sw_pop = 1'b1;
        #1;
        chk("R11 empty pop zero", 32'(rd_data), 32'd0);
        tick();
        sw_pop = 1'b0;
        chk("R11 rd stays low", 32'(rd_allowed), 32'd0);
        chk("R11 own unchanged", 32'(own_flag), 32'd1);
        pulse_ack();
        pulse_rel();
        chk("R7 reassert rx", 32'(rx_flag), 32'd1);
        chk("R7 reassert own", 32'(own_flag), 32'd1);
        chk("R8 next bank readable", 32'(rd_allowed), 32'd1);
        chk("R6 freed bank requests", 32'(tok_req), 32'd1);
        drain(64, "R6 R9");
        pulse_ack();
        pulse_rel();
        chk("R7 flags low next empty", 32'({rx_flag, own_flag}), 32'd0);
        serve(1, 1'b1);
        chk("R2 third request open", 32'(frozen), 32'd0);
        pulse_set();
        chk("R3 freeze stops req", 32'(tok_req), 32'd0);
        chk("R3 frozen set", 32'(frozen), 32'd1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule